// File: doc/BRIEF.md
# Two-Wire Control Register Slave for a Satellite Antenna Supply

This block is the serial control port of a power supply that feeds an outdoor antenna converter. A host writes configuration bytes over a two-wire serial bus (I2C signalling, SCL and SDA). The block keeps them in two 8-bit registers and drives the supply's control lines from them: output enable, high-voltage select, cable-loss compensation, continuous tone and pulsed current limiting. The host can read both registers back. Two bit positions in these registers return live fault inputs: overload and over-temperature.

SCL and SDA are oversampled by a system clock of at least 16 times the bus bit rate. The block drives SDA only through an output enable, so the pad can pull the line low and otherwise release it. A power-good input gates the whole block. While it is low, every register is forced to zero and the block stays off the bus, so the supply cannot be switched on.

Top module: `lnb_ctrl_slave`

## Requirements
- R1: The block answers the 7-bit address 000100A, where A is `addr_sel`. The eighth bit of the address byte selects the direction, with 1 for read and 0 for write.
- R2: Every byte is 8 bits long and sent MSB first. The block acknowledges an address byte it accepts, and each written data byte, by driving SDA low on the ninth clock. It changes its SDA drive only while SCL is low.
- R3: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A START or STOP in the middle of a byte drops that byte and returns the block to address matching, so a partly sent byte never reaches a register.
- R4: A written byte with bit 7 = 0 loads register 1 from bits 6..1. Bit 0 of register 1 is the overload status, and writes do not change it.
- R5: A written byte with bits 7:6 = 11 loads register 2, except bit 1, which is the over-temperature status and ignores writes. A byte with bits 7:6 = 10 is acknowledged but changes neither register.
- R6: The control outputs follow register 1: `out_dyn_limit` = bit 6, `out_tone_on` = bit 4, `out_line_comp` = bit 3, `out_v_high` = bit 2, `out_enable` = bit 1. Bit 5 is spare storage.
- R7: A read returns register bytes MSB first. Every read transaction starts with register 1 and then alternates register 2, register 1, and so on, as long as the master acknowledges. A master NACK ends the read, and the block releases SDA.
- R8: On a read, writable bits return their last written values. Register 1 bit 0 returns `olf_in`. Register 2 bit 1 returns `otf_in`.
- R9: While `pwr_good` is low, the block never acknowledges and both registers are zero, so every control output is 0. When `pwr_good` returns, the registers stay zero until they are written again.
- R10: After reset both registers are zero, every control output is 0, and `sda_oe` is 0.
- R11: An address byte with any other address gets no acknowledge. The block then ignores the bus until the next START, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Address LSB select |
| pwr_good | input | 1 | Supply healthy; low holds the block off the bus and cleared |
| olf_in | input | 1 | Live overload status |
| otf_in | input | 1 | Live over-temperature status |
| out_enable | output | 1 | Supply output enable |
| out_v_high | output | 1 | High output voltage select |
| out_line_comp | output | 1 | Cable-loss compensation step |
| out_tone_on | output | 1 | Continuous tone enable |
| out_dyn_limit | output | 1 | Pulsed (dynamic) current limit select |

## Verification
The hardest cases to reach are bus conditions that only a badly behaved master produces. One is a START or STOP that lands after four bits of a byte. The other is a loss of power-good while the registers hold live settings. The bench drives the bus one bit at a time, so it can cut a byte after any number of clocks and then send a repeated START, or a STOP, in place of the rest. It checks through read-back that nothing was committed. It drops power-good between complete transactions, tries a normal write while power is low, and then shows through a read that the registers came back cleared.

// File: rtl/lnbi_pkg.sv
// Shared constants and types for the two-wire control register slave.
// Assumes 8-bit bytes; bit positions are those the supply decodes.
package lnbi_pkg;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = $clog2(BYTE_W + 1);
    localparam int BIT_DCL    = 6;
    localparam int BIT_TONE   = 4;
    localparam int BIT_LLC    = 3;
    localparam int BIT_VSEL   = 2;
    localparam int BIT_EN     = 1;
    localparam int BIT_OLF    = 0;
    localparam int BIT_OTF    = 1;
    localparam int BIT_SEL_HI = 7;
    localparam int BIT_SEL_LO = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } bus_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/lnbi_line_sampler.sv
// Synchronises SCL and SDA into the system clock and derives clock edges,
// START and STOP. Assumes clk is at least 16x the bus bit rate, so each
// bus phase spans several samples. Idle bus level is high.
module lnbi_line_sampler
    import lnbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic [LANES-1:0] delayed;

    assign raw = {sda_in, scl_in};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SYNC_STAGES-1:0] pipe;
        // Metastability chain for one bus line.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[SYNC_STAGES-2:0], raw[l]};
        end
        assign synced[l] = pipe[SYNC_STAGES-1];
    end

    // One-sample history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) delayed <= '1;
        else        delayed <= synced;
    end

    // Event decode from current and previous samples.
    always_comb begin
        evt.scl      = synced[0];
        evt.sda      = synced[1];
        evt.scl_rise = synced[0] & ~delayed[0];
        evt.scl_fall = ~synced[0] & delayed[0];
        evt.start    = synced[0] & delayed[0] & delayed[1] & ~synced[1];
        evt.stop     = synced[0] & delayed[0] & ~delayed[1] & synced[1];
    end

    AST_ONE_BUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.start, evt.stop, evt.scl_rise, evt.scl_fall})); // R3
endmodule

// File: rtl/lnbi_sysregs.sv
// Holds the two system registers, decodes write bytes by their select bits,
// merges live status flags into read data and drives the control outputs.
// Assumes pwr_good is synchronous to clk; status inputs are synchronised here.
module lnbi_sysregs
    import lnbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_sel,
    input  logic              olf_raw,
    input  logic              otf_raw,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out_enable,
    output logic              out_v_high,
    output logic              out_line_comp,
    output logic              out_tone_on,
    output logic              out_dyn_limit
);
    localparam logic [BYTE_W-1:0] RO1_MASK = BYTE_W'(1) << BIT_OLF;
    localparam logic [BYTE_W-1:0] RO2_MASK = BYTE_W'(1) << BIT_OTF;

    logic [BYTE_W-1:0] reg1_q;
    logic [BYTE_W-1:0] reg2_q;
    logic [1:0]        stat_raw;
    logic [1:0]        stat_s;

    assign stat_raw = {otf_raw, olf_raw};

    for (genvar l = 0; l < 2; l++) begin : g_stat
        logic [SYNC_STAGES-1:0] pipe;
        // Synchroniser for one status flag.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[SYNC_STAGES-2:0], stat_raw[l]};
        end
        assign stat_s[l] = pipe[SYNC_STAGES-1];
    end

    // Register update: cleared while unpowered, written by select bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            reg1_q <= '0;
            reg2_q <= '0;
        end else if (wr_stb) begin
            if (!wr_byte[BIT_SEL_HI])
                reg1_q <= wr_byte & ~RO1_MASK;
            else if (wr_byte[BIT_SEL_LO])
                reg2_q <= wr_byte & ~RO2_MASK;
        end
    end

    // Read data with live status merged into the read-only positions.
    always_comb begin
        if (rd_sel) rd_byte = reg2_q | (BYTE_W'(stat_s[1]) << BIT_OTF);
        else        rd_byte = reg1_q | (BYTE_W'(stat_s[0]) << BIT_OLF);
    end

    assign out_enable    = reg1_q[BIT_EN];
    assign out_v_high    = reg1_q[BIT_VSEL];
    assign out_line_comp = reg1_q[BIT_LLC];
    assign out_tone_on   = reg1_q[BIT_TONE];
    assign out_dyn_limit = reg1_q[BIT_DCL];

    AST_REGS_ZERO_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (reg1_q == '0 && reg2_q == '0)); // R9
    AST_REGS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !wr_stb) |=> ($stable(reg1_q) && $stable(reg2_q))); // R4
endmodule

// File: rtl/lnbi_bus_fsm.sv
// Byte-level protocol engine: address match, ACK drive, write strobes,
// read shifting with register alternation. Works only on sampled events.
// Assumes no clock stretching and that pwr_good is synchronous to clk.
module lnbi_bus_fsm
    import lnbi_pkg::*;
#(
    parameter logic [BYTE_W-3:0] ADDR_HI = 6'b000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              addr_sel,
    input  logic              pwr_good,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              rd_sel,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              rd_ptr;
    logic              master_ack;
    logic              addr_hit;

    assign addr_hit = (sh[BYTE_W-1:1] == {ADDR_HI, addr_sel});
    assign rd_sel   = rd_ptr;
    assign wr_byte  = sh;

    // Protocol sequencing on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            tx         <= '0;
            rw         <= 1'b0;
            rd_ptr     <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
            wr_stb     <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == FULL) begin
                            if (addr_hit) begin
                                state  <= ST_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw     <= sh[0];
                                rd_ptr <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_byte << 1;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                rd_ptr <= ~rd_ptr;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == FULL) begin
                            wr_stb <= 1'b1;
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-1];
                                tx     <= tx << 1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            master_ack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (master_ack) begin
                                tx     <= rd_byte << 1;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                rd_ptr <= ~rd_ptr;
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_NO_ACK_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sda_oe); // R9
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && $past(pwr_good) && !$stable(sda_oe)) |-> !evt.scl); // R2
    AST_WRITE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_oe); // R2
endmodule

// File: rtl/lnb_ctrl_slave.sv
// Top of the two-wire control register slave for an antenna supply.
// Assumes an external open-drain pad: sda_oe = 1 pulls SDA low.
module lnb_ctrl_slave #(
    parameter int          SYNC_STAGES = 2,
    parameter logic [5:0]  ADDR_HI     = 6'b000100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic addr_sel,
    input  logic pwr_good,
    input  logic olf_in,
    input  logic otf_in,
    output logic out_enable,
    output logic out_v_high,
    output logic out_line_comp,
    output logic out_tone_on,
    output logic out_dyn_limit
);
    import lnbi_pkg::*;

    bus_evt_t          evt;
    logic              rd_sel;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;

    lnbi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    lnbi_bus_fsm #(.ADDR_HI(ADDR_HI)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .addr_sel (addr_sel),
        .pwr_good (pwr_good),
        .rd_byte  (rd_byte),
        .rd_sel   (rd_sel),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .sda_oe   (sda_oe)
    );

    lnbi_sysregs #(.SYNC_STAGES(SYNC_STAGES)) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .wr_stb        (wr_stb),
        .wr_byte       (wr_byte),
        .rd_sel        (rd_sel),
        .olf_raw       (olf_in),
        .otf_raw       (otf_in),
        .rd_byte       (rd_byte),
        .out_enable    (out_enable),
        .out_v_high    (out_v_high),
        .out_line_comp (out_line_comp),
        .out_tone_on   (out_tone_on),
        .out_dyn_limit (out_dyn_limit)
    );
endmodule

// File: tb/test_lnb_ctrl_slave.sv
`timescale 1ns/1ps
module test_lnb_ctrl_slave;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n, m_scl, m_sda, addr_sel, pwr_good, olf, otf;
    logic sda_oe, out_enable, out_v_high, out_line_comp, out_tone_on, out_dyn_limit;
    wire  sda_bus = m_sda & ~sda_oe;
    int   n_checks = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    lnb_ctrl_slave i_lnb_ctrl_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .pwr_good(pwr_good), .olf_in(olf), .otf_in(otf),
        .out_enable(out_enable), .out_v_high(out_v_high), .out_line_comp(out_line_comp),
        .out_tone_on(out_tone_on), .out_dyn_limit(out_dyn_limit)
    );

    function automatic logic [4:0] ctrl5();
        return {out_dyn_limit, out_tone_on, out_line_comp, out_v_high, out_enable};
    endfunction

    function automatic logic [6:0] dev();
        return {6'b000100, addr_sel};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~give_ack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                            output logic aa, output logic ad);
        bus_start();
        send_byte({a, 1'b0}, aa);
        send_byte(d, ad);
        bus_stop();
        tick(4);
    endtask

    task automatic do_read(input logic [6:0] a, input int nb, output logic aa,
                           output logic [7:0] b1, output logic [7:0] b2, output logic [7:0] b3);
        bus_start();
        send_byte({a, 1'b1}, aa);
        recv_byte(b1, 1'b1);
        recv_byte(b2, nb > 2);
        if (nb > 2) recv_byte(b3, 1'b0); else b3 = 8'h00;
        bus_stop();
        tick(4);
    endtask

    initial begin
        logic aa, ad;
        logic [7:0] b1, b2, b3, m1, m2;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; addr_sel = 1'b0;
        pwr_good = 1'b1; olf = 1'b0; otf = 1'b0;
        m1 = 8'h00; m2 = 8'h00;
        tick(10);
        chk("R10 sda_oe in reset", sda_oe, 0);
        chk("R10 controls in reset", ctrl5(), 0);
        rst_n = 1'b1; tick(5);
        do_read(dev(), 2, aa, b1, b2, b3);
        chk("R10 reg1 after reset", b1, 8'h00);
        chk("R10 reg2 after reset", b2, 8'h00);

        // R4 R6 R8: sweep every writable pattern of register 1
        for (int v = 0; v < 64; v++) begin
            addr_sel = v[0]; olf = v[1] ^ v[3]; otf = v[2]; tick(2);
            do_write(dev(), {1'b0, 6'(v), 1'b1}, aa, ad);
            chk("R1 address ack", aa, 1);
            chk("R2 data ack", ad, 1);
            chk("R6 control outputs", ctrl5(), {v[5], v[3], v[2], v[1], v[0]});
            m1 = {1'b0, 6'(v), 1'b0};
            do_read(dev(), 2, aa, b1, b2, b3);
            chk("R4 R8 reg1 readback", b1, m1 | {7'b0, olf});
            chk("R8 reg2 readback", b2, {m2[7:2], otf, m2[0]});
            chk("R7 sda released after NACK", sda_oe, 0);
        end

        // R5 R7: register 2 writes, three-byte reads alternate
        for (int w = 0; w < 16; w++) begin
            addr_sel = w[1]; otf = w[0]; olf = ~w[0]; tick(2);
            do_write(dev(), {2'b11, 4'(w), 1'b1, ~w[3]}, aa, ad);
            m2 = {2'b11, 4'(w), 1'b0, ~w[3]};
            chk("R5 reg2 write ack", ad, 1);
            chk("R5 controls unchanged by reg2", ctrl5(), 5'b11111);
            do_read(dev(), 3, aa, b1, b2, b3);
            chk("R7 first byte reg1", b1, m1 | {7'b0, olf});
            chk("R5 R8 second byte reg2", b2, {m2[7:2], otf, m2[0]});
            chk("R7 third byte reg1 again", b3, m1 | {7'b0, olf});
        end

        // R5: select 10 is acknowledged but writes nothing
        do_write(dev(), 8'b1000_0110, aa, ad);
        chk("R5 select10 ack", ad, 1);
        do_read(dev(), 2, aa, b1, b2, b3);
        chk("R5 select10 reg1 kept", b1, m1 | {7'b0, olf});
        chk("R5 select10 reg2 kept", b2, {m2[7:2], otf, m2[0]});

        // R1 R11: sweep every 7-bit address
        for (int a = 0; a < 128; a++) begin
            addr_sel = a[4]; tick(2);
            bus_start();
            send_byte({7'(a), 1'b0}, aa);
            bus_stop();
            chk("R1 R11 address sweep ack", aa, (7'(a) == dev()) ? 1 : 0);
        end
        chk("R11 controls after address sweep", ctrl5(), 5'b11111);
        do_write(7'h0A, 8'h00, aa, ad);
        chk("R11 foreign address no ack", aa, 0);
        chk("R11 following byte no ack", ad, 0);
        chk("R11 foreign write ignored", ctrl5(), 5'b11111);

        // R3: START after four address bits, then a full write
        bus_start();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({dev(), 1'b0}, aa);
        send_byte(8'h02, ad);
        bus_stop(); tick(4);
        chk("R3 restart address ack", aa, 1);
        chk("R3 write after restart", ctrl5(), 5'b00001);
        m1 = 8'h02;
        // R3: STOP after four data bits commits nothing
        bus_start();
        send_byte({dev(), 1'b0}, aa);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_stop(); tick(4);
        chk("R3 stop mid byte no change", ctrl5(), 5'b00001);
        // R3: START after four data bits, then a read
        bus_start();
        send_byte({dev(), 1'b0}, aa);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({dev(), 1'b1}, aa);
        recv_byte(b1, 1'b0);
        bus_stop(); tick(4);
        chk("R3 restart read ack", aa, 1);
        chk("R3 partial byte not committed", b1, m1 | {7'b0, olf});

        // R9: power-good low clears and silences the block
        do_write(dev(), 8'h7E, aa, ad);
        chk("R9 setup all controls on", ctrl5(), 5'b11111);
        pwr_good = 1'b0; tick(3);
        chk("R9 controls cleared unpowered", ctrl5(), 0);
        do_write(dev(), 8'h7E, aa, ad);
        chk("R9 no address ack unpowered", aa, 0);
        chk("R9 no data ack unpowered", ad, 0);
        chk("R9 controls stay zero", ctrl5(), 0);
        pwr_good = 1'b1; tick(3);
        chk("R9 controls zero after power return", ctrl5(), 0);
        do_read(dev(), 2, aa, b1, b2, b3);
        chk("R9 reg1 cleared", b1, {7'b0, olf});
        chk("R9 reg2 cleared", b2, {6'b0, otf, 1'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule